// File: doc/BRIEF.md
# Staged Per-Core Watchdog Timer

This block guards one processor core. Software programs a 16-bit length and a 2-bit mode in a single write. The length becomes the top 16 bits of a 24-bit down-counter whose low byte starts at zero. A prescaler lets that counter step once every `DIV` input clocks. Each time the counter runs out without a poke, the watchdog climbs one stage. The first expiry raises an interrupt, the second raises an NMI, and the third sends a one-cycle soft-reset request to the chip.

The mode caps how far that climb may go. Mode 0 is off, mode 1 stops after the interrupt, mode 2 stops after the NMI and mode 3 runs all the way to the reset request. Once the highest enabled stage is reached, the counter freezes. A poke reloads the counter and drops back to the first stage. The live count is always visible on an output, so software can see how close the next stage is.

Every pin is plain control or status. No data stream passes through the block, so no port uses a valid/ready handshake. The configuration write and the poke are single-cycle strobes that the block accepts in every cycle.

Top module: `wdg_staged_core`

## Requirements
- R1: While reset is asserted, and just after it is released, `count_o` reads 0 and `irq_o`, `nmi_o` and `soft_rst_o` are all low.
- R2: A configuration write with a nonzero length L and a nonzero mode loads `count_o` with L*256. `irq_o` rises exactly L*256*DIV clock edges after the edge that captured the write.
- R3: In mode 3 the three stages follow one period apart. `nmi_o` rises one period after `irq_o`, and `soft_rst_o` pulses one period after `nmi_o`. On every expiry `count_o` reloads to L*256, and after the reset stage it stays frozen there.
- R4: `irq_o` and `nmi_o` are levels that stay high until a poke or a configuration write. `nmi_o` is never high without `irq_o`. `soft_rst_o` is high for exactly one cycle per escalation.
- R5: In mode 1, after the interrupt stage the counter freezes at L*256 and `nmi_o` never rises.
- R6: In mode 2, after the NMI stage the counter freezes at L*256 and `soft_rst_o` never pulses.
- R7: A configuration write with mode 0 or with length 0 disables the watchdog. While disabled, `count_o` reads 0, no output asserts, and a poke changes nothing.
- R8: A poke while enabled reloads `count_o` to L*256, where L is the stored length. It clears `irq_o` and `nmi_o` on the next edge and restarts the prescaler, so decrementing resumes from a full period.
- R9: While the watchdog is counting, `count_o` drops by exactly one every DIV clocks. After k clocks from a load it reads L*256 - floor(k/DIV), for k below one period.
- R10: A configuration write takes priority over a poke in the same cycle and loads the newly written length. A configuration write in the middle of a run clears any raised stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle strobe that captures `cfg_len` and `cfg_mode` |
| cfg_len | input | 16 | Period length, the top 16 bits of the decrementer |
| cfg_mode | input | 2 | Escalation limit: 0 off, 1 interrupt, 2 NMI, 3 soft reset |
| poke | input | 1 | One-cycle keep-alive strobe |
| count_o | output | 24 | Live value of the decrementer |
| irq_o | output | 1 | Interrupt stage reached (level) |
| nmi_o | output | 1 | NMI stage reached (level) |
| soft_rst_o | output | 1 | One-cycle chip soft-reset request |

## Verification
The assertions assume that `DIV` is a power of two of at least 2. They also assume that `cfg_we`, `poke`, `cfg_len` and `cfg_mode` are synchronous to `clk` and never unknown after reset. The single-cycle tick spacing and the one-step decrement rule both depend on these assumptions.

The bench drives every input on the falling edge from fixed values, so nothing changes near the sampling edge. It instantiates the block with a small divisor so that full escalations fit in the run. The random phase picks lengths, modes and poke delays from a seeded `$urandom`. Each delay is kept below one period, so the expected count follows the floor formula of R9 without any stage firing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int LEN_W  = 16;
  localparam int FRAC_W = 8;
  localparam int CNT_W  = LEN_W + FRAC_W;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_IRQ   = 2'd1,
    ST_NMI   = 2'd2,
    ST_RESET = 2'd3
  } wdg_stage_e;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (restart || !run) begin
      pcnt_q <= '0;
    end else if (pcnt_q == LAST) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign tick = run && !restart && (pcnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             hold,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_q;

  assign expire = tick && !hold && (count_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= reload_val;
    end else if (tick && !hold && count_q != '0) begin
      count_q <= expire ? reload_val : count_q - 1'b1;
    end
  end

  assign count = count_q;

  AST_FROZEN_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load && !clear) |=> $stable(count_q)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !load && !clear && count_q > CNT_W'(1))
      |=> (count_q == $past(count_q) - 1'b1)); // R9
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       expire,
  input  logic [1:0] mode,
  output logic       at_limit,
  output logic       irq,
  output logic       nmi,
  output logic       rst_pulse
);
  wdg_stage_e stage_q;
  logic       pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_ARMED;
      pulse_q <= 1'b0;
    end else if (restart) begin
      stage_q <= ST_ARMED;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire && (stage_q == ST_NMI);
      if (expire) begin
        stage_q <= wdg_stage_e'(stage_q + 2'd1);
      end
    end
  end

  assign at_limit  = (stage_q >= mode);
  assign irq       = (stage_q != ST_ARMED);
  assign nmi       = (stage_q == ST_NMI) || (stage_q == ST_RESET);
  assign rst_pulse = pulse_q;

  AST_NMI_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> irq); // R4

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse); // R4

  AST_STAGE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (stage_q <= mode)); // R6

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (stage_q == ST_ARMED)); // R8
endmodule

// File: rtl/wdg_staged_core.sv
module wdg_staged_core
  import wdg_pkg::*;
#(
  parameter int DIV = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_mode,
  input  logic              poke,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              soft_rst_o
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic             active_q;

  logic             cfg_on;
  logic             load;
  logic             clear;
  logic             restart;
  logic             hold;
  logic             tick;
  logic             expire;
  logic             at_limit;
  logic [CNT_W-1:0] reload_val;

  assign cfg_on     = (cfg_mode != 2'd0) && (cfg_len != '0);
  assign load       = (cfg_we && cfg_on) || (!cfg_we && poke && active_q);
  assign clear      = cfg_we && !cfg_on;
  assign restart    = load || clear;
  assign reload_val = cfg_we ? {cfg_len, {FRAC_W{1'b0}}} : {len_q, {FRAC_W{1'b0}}};
  assign hold       = !active_q || at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      mode_q   <= 2'd0;
      active_q <= 1'b0;
    end else if (cfg_we) begin
      len_q    <= cfg_len;
      mode_q   <= cfg_on ? cfg_mode : 2'd0;
      active_q <= cfg_on;
    end
  end

  wdg_prescale #(.DIV(DIV)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!hold),
    .restart (restart),
    .tick    (tick)
  );

  wdg_countdown u_countdown (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .clear      (clear),
    .reload_val (reload_val),
    .tick       (tick),
    .hold       (hold),
    .count      (count_o),
    .expire     (expire)
  );

  wdg_escalate u_escalate (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .expire    (expire),
    .mode      (mode_q),
    .at_limit  (at_limit),
    .irq       (irq_o),
    .nmi       (nmi_o),
    .rst_pulse (soft_rst_o)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!irq_o && !nmi_o && !soft_rst_o && count_o == '0)); // R7

  AST_POKE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (poke && !cfg_we && active_q)
      |=> (count_o == {len_q, {FRAC_W{1'b0}}} && !irq_o && !nmi_o)); // R8

  AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_on) |=> (count_o == {len_q, {FRAC_W{1'b0}}} && !irq_o)); // R10
endmodule

// File: tb/wdg_staged_core_test.sv
module wdg_staged_core_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [1:0]  cfg_mode = '0;
  logic        poke = 1'b0;
  logic [23:0] count_o;
  logic        irq_o, nmi_o, soft_rst_o;

  int checks = 0;
  int errors = 0;
  int rst_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdg_staged_core #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .poke(poke), .count_o(count_o),
    .irq_o(irq_o), .nmi_o(nmi_o), .soft_rst_o(soft_rst_o)
  );

  always @(negedge clk) if (soft_rst_o) rst_seen++;

  function automatic int period(int len);
    return len * 256 * DIV;
  endfunction

  function automatic int exp_cnt(int len, int k);
    return len * 256 - k / DIV;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(int len, int mode);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len = 16'(len); cfg_mode = 2'(mode);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_poke();
    @(negedge clk);
    poke = 1'b1;
    @(negedge clk);
    poke = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int p;
    int rs;
    void'($urandom(32'h5eed_0042));
    wait_n(3);
    chk("R1 count in reset", int'(count_o), 0);
    chk("R1 irq in reset", int'(irq_o), 0);
    chk("R1 nmi in reset", int'(nmi_o), 0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 soft reset after release", int'(soft_rst_o), 0);
    chk("R1 count after release", int'(count_o), 0);

    // Full escalation in mode 3, length 1
    p = period(1);
    configure(1, 3);
    chk("R2 count after load", int'(count_o), 256);
    wait_n(p - 1);
    chk("R2 irq before period", int'(irq_o), 0);
    wait_n(1);
    chk("R2 irq at period", int'(irq_o), 1);
    chk("R3 reload on expiry", int'(count_o), 256);
    chk("R3 no nmi yet", int'(nmi_o), 0);
    wait_n(p - 1);
    chk("R3 nmi before second period", int'(nmi_o), 0);
    wait_n(1);
    chk("R3 nmi at second period", int'(nmi_o), 1);
    rs = rst_seen;
    wait_n(p - 1);
    chk("R3 no reset early", int'(soft_rst_o), 0);
    wait_n(1);
    chk("R3 reset pulse", int'(soft_rst_o), 1);
    wait_n(1);
    chk("R4 reset pulse one cycle", int'(soft_rst_o), 0);
    chk("R4 irq level held", int'(irq_o), 1);
    chk("R4 nmi level held", int'(nmi_o), 1);
    wait_n(p + 7);
    chk("R4 single reset pulse", rst_seen - rs, 1);
    chk("R3 frozen after reset stage", int'(count_o), 256);

    // Mode 1 stops at the interrupt
    p = period(2);
    configure(2, 1);
    wait_n(p);
    chk("R5 irq in mode 1", int'(irq_o), 1);
    wait_n(p + 5);
    chk("R5 no nmi in mode 1", int'(nmi_o), 0);
    chk("R5 count frozen", int'(count_o), 512);

    // Mode 2 stops at the NMI
    p = period(1);
    configure(1, 2);
    wait_n(2 * p);
    chk("R6 nmi in mode 2", int'(nmi_o), 1);
    rs = rst_seen;
    wait_n(p + 5);
    chk("R6 no reset in mode 2", rst_seen - rs, 0);
    chk("R6 count frozen", int'(count_o), 256);

    // Poke clears the stages and restarts the count
    do_poke();
    chk("R8 reload on poke", int'(count_o), 256);
    chk("R8 irq cleared", int'(irq_o), 0);
    chk("R8 nmi cleared", int'(nmi_o), 0);
    wait_n(10);
    chk("R8 prescaler restarted", int'(count_o), exp_cnt(1, 10));

    // Disabled configurations
    configure(5, 0);
    chk("R7 mode 0 count", int'(count_o), 0);
    wait_n(50);
    do_poke();
    wait_n(3);
    chk("R7 poke ignored", int'(count_o), 0);
    chk("R7 no irq", int'(irq_o), 0);
    configure(0, 3);
    wait_n(100);
    chk("R7 length 0 count", int'(count_o), 0);
    chk("R7 length 0 no irq", int'(irq_o), 0);

    // Configuration write beats a poke in the same cycle
    configure(1, 3);
    wait_n(100);
    @(negedge clk);
    cfg_we = 1'b1; poke = 1'b1; cfg_len = 16'd2; cfg_mode = 2'd3;
    @(negedge clk);
    cfg_we = 1'b0; poke = 1'b0;
    chk("R10 new length wins", int'(count_o), 512);
    configure(1, 3);
    wait_n(period(1));
    chk("R10 irq raised before rewrite", int'(irq_o), 1);
    configure(2, 1);
    chk("R10 rewrite clears irq", int'(irq_o), 0);
    chk("R10 rewrite loads count", int'(count_o), 512);

    // Seeded random runs
    for (int i = 0; i < 20; i++) begin
      int len;
      int mode;
      int k;
      int j;
      len  = 1 + int'($urandom % 2);
      mode = 1 + int'($urandom % 3);
      p    = period(len);
      configure(len, mode);
      k = int'($urandom % (p - 1));
      wait_n(k);
      chk("R9 random count", int'(count_o), exp_cnt(len, k));
      chk("R9 random no irq", int'(irq_o), 0);
      do_poke();
      chk("R8 random reload", int'(count_o), len * 256);
      j = int'($urandom % (p - 1));
      wait_n(j);
      chk("R8 random count after poke", int'(count_o), exp_cnt(len, j));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule